// File: doc/BRIEF.md
# Delayed Start Pulse Conditioner

This block sits between a loosely timed start request and the sequencer of a successive-approximation converter. The request may arrive in any phase of the clock and may last any number of cycles. The block turns each new request into a clean start pulse one clock wide. That pulse is held back by a fixed number of clocks, so it can never land in the short quiet interval that follows the converter's conversion-done rise.

The raw request first passes through a two-flop synchroniser. Its rising edge then sets a pending-request latch. The latch output runs down a delay shift register, and an edge-to-pulse stage at the end of that register makes the single-cycle output. The converter reports its state on `conv_done`: high means idle, low means busy. The latch stays set until the clock edge that first sees `conv_done` low. Because of this, a request made just after `conv_done` rises is held and not lost. Any request that arrives while the latch is already set is merged into the pending one.

Top module: `start_pulse_shaper`

## Requirements
- R1: A synchronous, active-high `rst` clears the synchroniser, the latch and every delay stage. `start_o` is low in the cycle after a reset edge. A request latched before that reset edge never produces a pulse.
- R2: One rising edge on `start_req`, held high for at least one clock, produces exactly one pulse on `start_o`.
- R3: Let E0 be the clock edge that first samples `start_req` high, with the latch clear and the delay register drained. Then `start_o` is high in the cycle after edge E0+6, which is SYNC_STAGES+DELAY_STAGES edges with the default parameters.
- R4: `start_o` is never high for two consecutive cycles.
- R5: A `start_req` held high for many cycles gives only one pulse, because only its rising edge makes a request.
- R6: A request whose latch-set edge comes while the latch is still set is merged with the pending request and gives no extra pulse. This holds both before and after the pending request's pulse.
- R7: The latch clears on the first clock edge that samples `conv_done` low after it was high. A request that sets the latch one edge before that clear is merged and gives no pulse. A request made after the clear gives a new pulse with the R3 latency.
- R8: When a latch set and a clear fall on the same edge, the set wins. A one-cycle gap is put into the delay register, so the new request still gives its own pulse, E0+6 edges after its E0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Raw start request, not related to the clock |
| conv_done | input | 1 | Converter state: high when idle, low when busy |
| start_o | output | 1 | Delayed start pulse, one clock wide |

## Verification
A latch that is stuck set or that clears too early shows at the port as a missing or extra pulse. A wrong clear edge shows at the boundary between R7 and R8: a request set one edge early must vanish, while one set on the clear edge must survive. A wrong delay depth or synchroniser depth moves the pulse away from edge E0+6, and the bench sees this within seven cycles of the request. A broken edge-to-pulse stage either stretches `start_o` over the whole time the latch is set or adds a second pulse after a merge, and this is visible within one drain time of the delay register.

// File: rtl/start_pulse_shaper.sv
module start_pulse_shaper #(
  parameter int SYNC_STAGES  = 2,
  parameter int DELAY_STAGES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic conv_done,
  output logic start_o
);

  localparam int SW = SYNC_STAGES;
  localparam int DW = DELAY_STAGES;

  logic [SW-1:0] sync_q;
  logic          sync_prev;
  logic          req_q;
  logic          done_q;
  logic [DW-1:0] dly_q;
  logic          dly_tail;
  logic          set_evt;
  logic          clr_evt;

  assign set_evt = sync_q[SW-1] & ~sync_prev;
  assign clr_evt = done_q & ~conv_done;
  assign start_o = dly_q[DW-1] & ~dly_tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      sync_prev <= 1'b0;
      req_q     <= 1'b0;
      done_q    <= 1'b0;
      dly_q     <= '0;
      dly_tail  <= 1'b0;
    end else begin
      sync_q    <= (sync_q << 1) | SW'(start_req);
      sync_prev <= sync_q[SW-1];
      done_q    <= conv_done;
      if (set_evt)      req_q <= 1'b1;
      else if (clr_evt) req_q <= 1'b0;
      dly_q     <= (dly_q << 1) | DW'(req_q & ~clr_evt);
      dly_tail  <= dly_q[DW-1];
    end
  end

endmodule

// File: rtl/start_pulse_shaper_chk.sv
module start_pulse_shaper_chk (
  input logic clk,
  input logic rst,
  input logic conv_done,
  input logic done_q,
  input logic set_evt,
  input logic req_q,
  input logic start_o
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !start_o); // R1

  AST_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o); // R4

  AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (done_q && !conv_done && !set_evt) |=> !req_q); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> req_q); // R8

endmodule

bind start_pulse_shaper start_pulse_shaper_chk u_chk (
  .clk(clk), .rst(rst), .conv_done(conv_done), .done_q(done_q),
  .set_evt(set_evt), .req_q(req_q), .start_o(start_o)
);

// File: tb/start_pulse_shaper_test.sv
module start_pulse_shaper_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic conv_done = 1'b1;
  logic start_o;

  int cyc = 0;
  int pulses = 0;
  int last_cyc = -1;
  int wide = 0;
  logic prev_o = 1'b0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam int LAT = 6;

  start_pulse_shaper uut (
    .clk(clk), .rst(rst), .start_req(start_req),
    .conv_done(conv_done), .start_o(start_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (start_o === 1'b1) begin
      pulses   <= pulses + 1;
      last_cyc <= cyc;
      if (prev_o === 1'b1) wide <= wide + 1;
    end
    prev_o <= start_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flush();
    @(negedge clk); conv_done = 1'b0;
    @(negedge clk); conv_done = 1'b1;
    idle(12);
  endtask

  task automatic t_reset();
    int p0, k;
    idle(3);
    chk(start_o == 1'b0, "R1 output low in reset", int'(start_o), 0);
    rst = 1'b0;
    idle(2);
    p0 = pulses;
    @(negedge clk); k = cyc; start_req = 1'b1;
    idle(2); start_req = 1'b0;
    idle(2); rst = 1'b1;
    @(negedge clk);
    chk(start_o == 1'b0, "R1 output low after reset edge", int'(start_o), 0);
    rst = 1'b0;
    idle(12);
    chk(pulses == p0, "R1 pending request discarded", pulses - p0, 0);
  endtask

  task automatic t_single();
    int p0, k;
    p0 = pulses;
    @(negedge clk); k = cyc; start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    idle(12);
    chk(pulses - p0 == 1, "R2 one pulse per request", pulses - p0, 1);
    chk(last_cyc == k + 1 + LAT, "R3 pulse latency", last_cyc, k + 1 + LAT);
    flush();
  endtask

  task automatic t_long();
    int p0, k;
    p0 = pulses;
    @(negedge clk); k = cyc; start_req = 1'b1;
    idle(25); start_req = 1'b0;
    idle(4);
    chk(pulses - p0 == 1, "R5 held request gives one pulse", pulses - p0, 1);
    chk(last_cyc == k + 1 + LAT, "R3 latency with held request", last_cyc, k + 1 + LAT);
    chk(wide == 0, "R4 pulse one clock wide", wide, 0);
    flush();
  endtask

  task automatic t_merge();
    int p0;
    p0 = pulses;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    idle(1);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    idle(12);
    chk(pulses - p0 == 1, "R6 merge before pulse", pulses - p0, 1);
    p0 = pulses;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    idle(14);
    chk(pulses - p0 == 0, "R6 merge after pulse", pulses - p0, 0);
    flush();
  endtask

  task automatic t_clear_edge();
    int p0, k;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    idle(10);
    p0 = pulses;
    @(negedge clk); start_req = 1'b1;
    idle(2); start_req = 1'b0;
    @(negedge clk); conv_done = 1'b0;
    idle(2); conv_done = 1'b1;
    idle(12);
    chk(pulses - p0 == 0, "R7 set one edge before clear is merged", pulses - p0, 0);
    p0 = pulses;
    @(negedge clk); k = cyc; start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    idle(12);
    chk(pulses - p0 == 1, "R7 new request after clear", pulses - p0, 1);
    chk(last_cyc == k + 1 + LAT, "R7 latency after clear", last_cyc, k + 1 + LAT);
    flush();
  endtask

  task automatic t_coincide();
    int p0, k;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    idle(10);
    p0 = pulses;
    @(negedge clk); k = cyc; start_req = 1'b1;
    @(negedge clk);
    @(negedge clk); start_req = 1'b0; conv_done = 1'b0;
    idle(2); conv_done = 1'b1;
    idle(10);
    chk(pulses - p0 == 1, "R8 set wins over clear", pulses - p0, 1);
    chk(last_cyc == k + 1 + LAT, "R8 pulse latency", last_cyc, k + 1 + LAT);
    chk(wide == 0, "R4 no wide pulse overall", wide, 0);
    flush();
  endtask

  initial begin
    t_reset();
    t_single();
    t_long();
    t_merge();
    t_clear_edge();
    t_coincide();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule